// File: doc/BRIEF.md
# Matrix Keypad Selection Encoder

This block sits between a three-by-three selection keypad, with a separate coin-return key, and a vending controller. Each of the seven raw wires arrives asynchronously and may bounce. The block brings each wire into the clock domain, filters it through its own debounce counter, and then decodes the filtered row and column wires. A key counts as pressed only when exactly one row and exactly one column are high together.

When a legal key appears, the block loads its item number into an output register. It also raises a press strobe for one clock. The register keeps the number after the key is released, so the controller can read the selection at any later time. Patterns with two keys, or with a row or column asserted alone, produce no strobe and leave the register unchanged. The coin-return key has its own strobe, which fires once on its filtered rising edge.

The debounce window is a parameter. At a 1 MHz clock it is 10,000 cycles, which covers a 10 ms settling time. A bench can set it much shorter.

Top module: `keypad_select_encoder`

## Requirements
- R1: After reset, `item_num` is 0 and both `press_stb` and `ret_stb` are low.
- R2: Row wire `row_in[r]` and column wire `col_in[c]` both high, with no other row or column high, name the key r*COLS+c+1. This numbering is row-major: row 0 holds keys 1 to 3, row 1 holds 4 to 6, row 2 holds 7 to 9. A newly pressed legal key pulses `press_stb` for one clock, and that key's number is in `item_num` in the same cycle.
- R3: While a key is held, `press_stb` does not fire again, even if other keys are added and removed. After every row and column wire has been released and filtered, a new press fires again.
- R4: Two or more rows, or two or more columns, high at once give no `press_stb`, and `item_num` is left unchanged.
- R5: A row high with no column, or a column high with no row, gives no `press_stb`, and `item_num` is left unchanged.
- R6: `item_num` keeps the last legal selection after all keys are released.
- R7: `ret_stb` pulses for one clock on the filtered rising edge of `ret_in`. It does not pulse on release, and it does not touch `item_num` or `press_stb`.
- R8: An input level that lasts fewer than DEB_CYCLES clocks has no effect on any output.
- R9: An illegal pattern that changes into a legal one without a full release gives a single `press_stb`, carrying the legal key's number.
- R10: A legal key applied from the released state raises `press_stb` in the cycle after the (DEB_CYCLES+3)-th rising clock edge that follows the input change, and not before. The delay comes from two synchronizer stages, DEB_CYCLES filter cycles and the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_in | input | ROWS (3) | Raw row wires, high when a key in that row is down |
| col_in | input | COLS (3) | Raw column wires, high when a key in that column is down |
| ret_in | input | 1 | Raw coin-return key, high when down |
| item_num | output | ITEM_W (4) | Registered number of the last legal key |
| press_stb | output | 1 | One-clock pulse when a legal key is newly detected |
| ret_stb | output | 1 | One-clock pulse when the coin-return key is pressed |

## Verification
The hardest case to reach from the ports is a pattern that resolves into a legal key without passing through the released state. The press logic must then fire once, and must not fire again when the extra keys come and go. The stimulus reaches this case by holding two rows until they are filtered, then dropping one row. It also adds a second key on top of a held key and removes it again. A full sweep of all 64 row/column combinations covers every legal and illegal pattern from a clean release. Pulses one clock shorter than the filter window, and an exact-cycle latency probe, pin down the filter boundary.

// File: rtl/keysel_pkg.sv
package keysel_pkg;

  localparam int unsigned MAX_LINES = 16;

  // true when exactly one bit of the vector is set
  function automatic logic single_hot(input logic [MAX_LINES-1:0] v);
    return (v != '0) && ((v & (v - 1'b1)) == '0);
  endfunction

endpackage

// File: rtl/keysel_debounce.sv
module keysel_debounce #(
  parameter int unsigned DEB_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic level_out
);
  localparam int unsigned CNT_W = $clog2(DEB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

  logic             sync_a, sync_b;
  logic             stable_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
    end else begin
      sync_a <= raw_in;
      sync_b <= sync_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_q <= 1'b0;
      cnt_q    <= '0;
    end else if (sync_b == stable_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      stable_q <= sync_b;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level_out = stable_q;

  // filtered level moves only after a full window of disagreement
  assert_full_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stable_q != $past(stable_q)) |-> ($past(cnt_q) == CNT_LAST));

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);

endmodule

// File: rtl/keysel_decode.sv
module keysel_decode
  import keysel_pkg::*;
#(
  parameter int unsigned ROWS   = 3,
  parameter int unsigned COLS   = 3,
  parameter int unsigned ITEM_W = 4
) (
  input  logic [ROWS-1:0]   rows,
  input  logic [COLS-1:0]   cols,
  output logic              legal,
  output logic              idle,
  output logic [ITEM_W-1:0] number
);
  logic [ITEM_W-1:0] ridx, cidx;
  logic              row_one, col_one;

  always_comb begin
    ridx = '0;
    for (int i = 0; i < ROWS; i++) begin
      if (rows[i]) ridx = ITEM_W'(i);
    end
    cidx = '0;
    for (int j = 0; j < COLS; j++) begin
      if (cols[j]) cidx = ITEM_W'(j);
    end
  end

  assign row_one = single_hot(MAX_LINES'(rows));
  assign col_one = single_hot(MAX_LINES'(cols));
  assign legal   = row_one && col_one;
  assign idle    = (rows == '0) && (cols == '0);
  assign number  = ridx * ITEM_W'(COLS) + cidx + ITEM_W'(1);

  // a legal decode is never an idle pad (R4/R5 relation)
  always_comb begin
    assert_legal_not_idle_R5: assert (!(legal && idle));
  end

endmodule

// File: rtl/keysel_strobe.sv
module keysel_strobe #(
  parameter int unsigned ITEM_W = 4,
  parameter int unsigned NKEYS  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              legal,
  input  logic              idle,
  input  logic [ITEM_W-1:0] number,
  input  logic              ret_lvl,
  output logic [ITEM_W-1:0] item_num,
  output logic              press_stb,
  output logic              ret_stb
);
  logic armed_q, ret_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b1;
      press_stb <= 1'b0;
      item_num  <= '0;
    end else begin
      press_stb <= 1'b0;
      if (legal && armed_q) begin
        press_stb <= 1'b1;
        item_num  <= number;
        armed_q   <= 1'b0;
      end else if (idle) begin
        armed_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_prev_q <= 1'b0;
      ret_stb    <= 1'b0;
    end else begin
      ret_prev_q <= ret_lvl;
      ret_stb    <= ret_lvl && !ret_prev_q;
    end
  end

  assert_press_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    press_stb |=> !press_stb);

  assert_item_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (item_num != $past(item_num)) |-> press_stb);

  assert_item_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    press_stb |-> (item_num >= ITEM_W'(1) && item_num <= ITEM_W'(NKEYS)));

  assert_ret_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_stb |=> !ret_stb);

endmodule

// File: rtl/keypad_select_encoder.sv
module keypad_select_encoder #(
  parameter int unsigned ROWS       = 3,
  parameter int unsigned COLS       = 3,
  parameter int unsigned ITEM_W     = 4,
  parameter int unsigned DEB_CYCLES = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROWS-1:0]   row_in,
  input  logic [COLS-1:0]   col_in,
  input  logic              ret_in,
  output logic [ITEM_W-1:0] item_num,
  output logic              press_stb,
  output logic              ret_stb
);
  localparam int unsigned NLINES = ROWS + COLS + 1;
  localparam int unsigned NKEYS  = ROWS * COLS;

  logic [NLINES-1:0] raw_vec, flt_vec;
  logic [ROWS-1:0]   rows_f;
  logic [COLS-1:0]   cols_f;
  logic              ret_f;
  logic              legal, idle;
  logic [ITEM_W-1:0] number;

  assign raw_vec = {ret_in, col_in, row_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_deb
    keysel_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_in    (raw_vec[g]),
      .level_out (flt_vec[g])
    );
  end

  assign rows_f = flt_vec[ROWS-1:0];
  assign cols_f = flt_vec[ROWS+COLS-1:ROWS];
  assign ret_f  = flt_vec[NLINES-1];

  keysel_decode #(.ROWS(ROWS), .COLS(COLS), .ITEM_W(ITEM_W)) u_dec (
    .rows   (rows_f),
    .cols   (cols_f),
    .legal  (legal),
    .idle   (idle),
    .number (number)
  );

  keysel_strobe #(.ITEM_W(ITEM_W), .NKEYS(NKEYS)) u_stb (
    .clk       (clk),
    .rst_n     (rst_n),
    .legal     (legal),
    .idle      (idle),
    .number    (number),
    .ret_lvl   (ret_f),
    .item_num  (item_num),
    .press_stb (press_stb),
    .ret_stb   (ret_stb)
  );

  assert_strobe_disjoint_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_stb |-> $stable(item_num));

endmodule

// File: tb/keypad_select_encoder_bench.sv
module keypad_select_encoder_bench;
  localparam int DEB = 8;
  localparam int SETTLE = DEB + 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] row_in = '0;
  logic [2:0] col_in = '0;
  logic       ret_in = 1'b0;
  logic [3:0] item_num;
  logic       press_stb, ret_stb;

  int checks = 0;
  int errors = 0;
  int press_cnt = 0;
  int ret_cnt = 0;
  int last_item = 0;

  always #5 clk = ~clk;

  keypad_select_encoder #(.DEB_CYCLES(DEB)) u_keypad_select_encoder (
    .clk(clk), .rst_n(rst_n), .row_in(row_in), .col_in(col_in), .ret_in(ret_in),
    .item_num(item_num), .press_stb(press_stb), .ret_stb(ret_stb)
  );

  always @(posedge clk) begin
    #2;
    if (press_stb) press_cnt++;
    if (ret_stb) ret_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit one3(input logic [2:0] v);
    return v == 3'b001 || v == 3'b010 || v == 3'b100;
  endfunction

  function automatic int idx3(input logic [2:0] v);
    return v[2] ? 2 : (v[1] ? 1 : 0);
  endfunction

  task automatic release_all();
    row_in = '0; col_in = '0;
    cyc(SETTLE);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    cyc(3);
    chk(item_num == 0, "R1 item after reset", item_num, 0);
    chk(press_stb == 0 && ret_stb == 0, "R1 strobes after reset", press_stb + ret_stb, 0);
    rst_n = 1'b1;
    cyc(SETTLE);
    chk(press_cnt == 0 && item_num == 0, "R1 idle after reset", press_cnt, 0);

    // exhaustive sweep over all row/column patterns (R2, R4, R5, R6)
    for (int p = 1; p < 64; p++) begin
      logic [2:0] r, c;
      bit good;
      int exp_item;
      r = p[2:0]; c = p[5:3];
      good = one3(r) && one3(c);
      exp_item = good ? idx3(r) * 3 + idx3(c) + 1 : last_item;
      base = press_cnt;
      row_in = r; col_in = c;
      cyc(SETTLE);
      if (good) begin
        chk(press_cnt - base == 1, "R2 one strobe per legal key", press_cnt - base, 1);
        chk(item_num == exp_item, "R2 item number", item_num, exp_item);
      end else if (r == 0 || c == 0) begin
        chk(press_cnt - base == 0, "R5 half pattern strobe", press_cnt - base, 0);
        chk(item_num == exp_item, "R5 half pattern item", item_num, exp_item);
      end else begin
        chk(press_cnt - base == 0, "R4 multi key strobe", press_cnt - base, 0);
        chk(item_num == exp_item, "R4 multi key item", item_num, exp_item);
      end
      last_item = exp_item;
      release_all();
      chk(item_num == last_item, "R6 item held after release", item_num, last_item);
    end

    // R3: hold, add and remove a second key, re-press after release
    base = press_cnt;
    row_in = 3'b010; col_in = 3'b010;
    cyc(3 * DEB);
    row_in = 3'b011;
    cyc(SETTLE);
    row_in = 3'b010;
    cyc(SETTLE);
    chk(press_cnt - base == 1, "R3 no refire while held", press_cnt - base, 1);
    chk(item_num == 5, "R3 held key item", item_num, 5);
    release_all();
    row_in = 3'b100; col_in = 3'b001;
    cyc(SETTLE);
    chk(press_cnt - base == 2, "R3 refire after release", press_cnt - base, 2);
    chk(item_num == 7, "R3 second key item", item_num, 7);
    release_all();

    // R9: illegal pattern resolves to legal without release
    base = press_cnt;
    row_in = 3'b011; col_in = 3'b001;
    cyc(SETTLE);
    chk(press_cnt - base == 0, "R9 illegal stage quiet", press_cnt - base, 0);
    row_in = 3'b001;
    cyc(SETTLE);
    chk(press_cnt - base == 1, "R9 resolved strobe", press_cnt - base, 1);
    chk(item_num == 1, "R9 resolved item", item_num, 1);
    release_all();

    // R8: pulses one clock short of the window
    base = press_cnt;
    row_in = 3'b100; col_in = 3'b100;
    cyc(DEB - 1);
    row_in = '0; col_in = '0;
    cyc(SETTLE);
    chk(press_cnt - base == 0, "R8 short key pulse", press_cnt - base, 0);
    chk(item_num == 1, "R8 item untouched", item_num, 1);
    base = ret_cnt;
    ret_in = 1'b1;
    cyc(DEB - 1);
    ret_in = 1'b0;
    cyc(SETTLE);
    chk(ret_cnt - base == 0, "R8 short return pulse", ret_cnt - base, 0);

    // R10: exact latency from released state
    row_in = 3'b010; col_in = 3'b100;
    cyc(DEB + 2);
    chk(press_stb == 0, "R10 not early", press_stb, 0);
    cyc(1);
    chk(press_stb == 1, "R10 strobe on time", press_stb, 1);
    chk(item_num == 6, "R10 item on time", item_num, 6);
    cyc(1);
    chk(press_stb == 0, "R2 strobe one clock", press_stb, 0);
    release_all();

    // R7: coin return
    base = ret_cnt;
    begin
      int pbase;
      pbase = press_cnt;
      ret_in = 1'b1;
      cyc(SETTLE);
      chk(ret_cnt - base == 1, "R7 one return strobe", ret_cnt - base, 1);
      ret_in = 1'b0;
      cyc(SETTLE);
      chk(ret_cnt - base == 1, "R7 no strobe on release", ret_cnt - base, 1);
      chk(press_cnt - pbase == 0, "R7 no press", press_cnt - pbase, 0);
      chk(item_num == 6, "R7 item untouched", item_num, 6);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule